// File: doc/BRIEF.md
# Host-Requested Device Wake Controller

This block is a single 32-bit control and status word. Through it a host manages the power state of an internal core. The host writes two control bits. The first (`init_done`) moves the device into full operation. The second (`wake_req`) asks the core to come up and to stay up while the bit stays set. The host reads back whether the core clock is ready, whether the core is about to drop into sleep, the power-save mode, the board strap pins and the hardware radio-kill switch. The word can be read and written at any time, including while the core is powered down.

A small power model sits inside the block. It stands in for the core's power sequencing and has two programmable delays. It wakes the core a fixed number of cycles after the host asks for it, and it walks through a going-to-sleep phase before the clock is lost. A separate grant output tells the host side when internal resources may actually be touched. A software-reset input returns the control bits, and the core, to low power at once.

Top module: `wake_ctrl`

## Requirements
- R1: After reset `rd_data_o` is 0x0100_0000 (only the power-mode field is nonzero, at 001) while the strap and radio-kill pins are low, and `grant_o` is 0.
- R2: Bit 2 (`init_done`) and bit 3 (`wake_req`) take the value of the matching `wr_data_i` bits on a cycle with `wr_en_i` high. All other bits ignore writes. Bits 1, 5, 23:10 and 31:28 always read 0.
- R3: When `init_done` and `wake_req` are both set by a write, bit 0 (clock ready) reads 1 exactly WAKE_DLY+1 clock edges after the write edge and stays 0 before that.
- R4: Bit 0 stays 0 while `init_done` is clear, whatever the value of `wake_req`.
- R5: `grant_o` is 1 exactly when `wake_req`, clock ready and not going-to-sleep (bit 4) all hold. It falls in the same cycle that `wake_req` reads 0.
- R6: When `wake_req` or `init_done` is cleared while the core is ready, bit 4 and bit 0 both read 1 for SLEEP_DLY edges after the core model reacts. On the next edge both read 0.
- R7: If the wake demand goes away before clock ready rises, the wake is abandoned: clock ready stays 0, and a later request waits the full WAKE_DLY+1 edges again.
- R8: `sw_reset_i` clears `init_done` and `wake_req` on the edge where it is high, even if a write is also present. Bits 0 and 4 read 0 after that same edge.
- R9: Bits 26:24 give the power mode, chosen in this priority: 011 (error) when `wake_req` is set and `init_done` is clear; else 010 (radio down) when the synchronized radio-kill pin is high; else 001 (core down) when clock ready is 0; else 000 (no power saving).
- R10: Bits 9:6 show `board_cfg_i` and bit 27 shows `rfkill_i`, each after SYNC_STAGES clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_reset_i | input | 1 | Software reset: drops control bits and core to low power |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 32 | Write data; only bits 3 and 2 are used |
| rd_data_o | output | 32 | Current control and status word |
| grant_o | output | 1 | Internal resources may be accessed |
| board_cfg_i | input | 4 | Board strap pins (asynchronous) |
| rfkill_i | input | 1 | Hardware radio-kill switch (asynchronous) |

## Verification
A power model stuck in the wrong state shows up at once on bits 0 and 4, and on `grant_o`. A fault in the wake or sleep counter moves the rise of clock ready or the fall of going-to-sleep by one or more edges. The bench therefore samples those bits after every single edge of each transition, not only at the end. Control-bit faults show up in the edge right after a write or a software reset, both in bits 3:2 and in the power-mode field. A wrong synchronizer depth shows as a strap or radio-kill value that appears one edge early or late.

// File: rtl/wake_pkg.sv
`timescale 1ns/1ps
package wake_pkg;

    localparam int WORD_W   = 32;
    localparam int STRAP_W  = 4;
    localparam int MODE_W   = 3;

    localparam int BIT_INIT = 2;
    localparam int BIT_REQ  = 3;

    typedef enum logic [MODE_W-1:0] {
        PM_NONE       = 3'b000,
        PM_CORE_DOWN  = 3'b001,
        PM_RADIO_DOWN = 3'b010,
        PM_ERROR      = 3'b011
    } pmode_t;

    typedef enum logic [1:0] {
        CORE_ASLEEP,
        CORE_WAKING,
        CORE_AWAKE,
        CORE_SLEEPING
    } core_state_t;

    // Status word layout, most significant field first.
    typedef struct packed {
        logic [3:0]         pad_hi;     // 31:28
        logic               radio_kill; // 27
        pmode_t             mode;       // 26:24
        logic [13:0]        pad_mid;    // 23:10
        logic [STRAP_W-1:0] strap;      // 9:6
        logic               pad_b5;     // 5
        logic               to_sleep;   // 4
        logic               wake_req;   // 3
        logic               init_done;  // 2
        logic               pad_b1;     // 1
        logic               clk_ready;  // 0
    } status_t;

    function automatic pmode_t pick_mode(input logic req, input logic init,
                                         input logic rkill, input logic ready);
        if (req && !init)  return PM_ERROR;
        else if (rkill)    return PM_RADIO_DOWN;
        else if (!ready)   return PM_CORE_DOWN;
        else               return PM_NONE;
    endfunction

    function automatic status_t pack_status(input logic ready, input logic init,
                                            input logic req, input logic sleepy,
                                            input logic [STRAP_W-1:0] strap,
                                            input logic rkill, input pmode_t mode);
        status_t s;
        s            = '0;
        s.clk_ready  = ready;
        s.init_done  = init;
        s.wake_req   = req;
        s.to_sleep   = sleepy;
        s.strap      = strap;
        s.mode       = mode;
        s.radio_kill = rkill;
        return s;
    endfunction

endpackage

// File: rtl/wake_pin_sync.sv
`timescale 1ns/1ps
module wake_pin_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] pin_o
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= pin_i;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[g] <= '0;
            else     stage_q[g] <= stage_q[g-1];
        end
    end

    assign pin_o = stage_q[STAGES-1];
endmodule

// File: rtl/wake_host_regs.sv
`timescale 1ns/1ps
module wake_host_regs (
    input  logic clk,
    input  logic rst,
    input  logic sw_reset_i,
    input  logic wr_en_i,
    input  logic wr_init_i,
    input  logic wr_req_i,
    output logic init_q,
    output logic req_q
);
    always_ff @(posedge clk) begin
        if (rst || sw_reset_i) begin
            init_q <= 1'b0;
            req_q  <= 1'b0;
        end else if (wr_en_i) begin
            init_q <= wr_init_i;
            req_q  <= wr_req_i;
        end
    end
endmodule

// File: rtl/wake_core_model.sv
`timescale 1ns/1ps
module wake_core_model
    import wake_pkg::*;
#(
    parameter int WAKE_DLY  = 8,
    parameter int SLEEP_DLY = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic sw_reset_i,
    input  logic demand_i,
    output logic clk_ready_o,
    output logic to_sleep_o
);
    localparam int MAX_DLY = (WAKE_DLY > SLEEP_DLY) ? WAKE_DLY : SLEEP_DLY;
    localparam int CNT_W   = $clog2(MAX_DLY + 1);
    localparam logic [CNT_W-1:0] WAKE_LOAD  = CNT_W'(WAKE_DLY - 1);
    localparam logic [CNT_W-1:0] SLEEP_LOAD = CNT_W'(SLEEP_DLY - 1);

    core_state_t      state_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || sw_reset_i) begin
            state_q <= CORE_ASLEEP;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                CORE_ASLEEP: if (demand_i) begin
                    state_q <= CORE_WAKING;
                    cnt_q   <= WAKE_LOAD;
                end
                CORE_WAKING: begin
                    if (!demand_i)          state_q <= CORE_ASLEEP;
                    else if (cnt_q == '0)   state_q <= CORE_AWAKE;
                    else                    cnt_q   <= cnt_q - 1'b1;
                end
                CORE_AWAKE: if (!demand_i) begin
                    state_q <= CORE_SLEEPING;
                    cnt_q   <= SLEEP_LOAD;
                end
                CORE_SLEEPING: begin
                    if (cnt_q == '0) state_q <= CORE_ASLEEP;
                    else             cnt_q   <= cnt_q - 1'b1;
                end
                default: state_q <= CORE_ASLEEP;
            endcase
        end
    end

    assign clk_ready_o = (state_q == CORE_AWAKE) || (state_q == CORE_SLEEPING);
    assign to_sleep_o  = (state_q == CORE_SLEEPING);
endmodule

// File: rtl/wake_ctrl.sv
`timescale 1ns/1ps
module wake_ctrl
    import wake_pkg::*;
#(
    parameter int WAKE_DLY    = 8,
    parameter int SLEEP_DLY   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sw_reset_i,
    input  logic               wr_en_i,
    input  logic [WORD_W-1:0]  wr_data_i,
    output logic [WORD_W-1:0]  rd_data_o,
    output logic               grant_o,
    input  logic [STRAP_W-1:0] board_cfg_i,
    input  logic               rfkill_i
);
    localparam int PIN_W = STRAP_W + 1;

    logic init_q, req_q;
    logic ready, sleepy;
    logic [PIN_W-1:0] pins_s;
    logic wr_unused;
    status_t status;

    assign wr_unused = ^{wr_data_i[WORD_W-1:BIT_REQ+1], wr_data_i[BIT_INIT-1:0]};

    wake_host_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .sw_reset_i(sw_reset_i),
        .wr_en_i   (wr_en_i),
        .wr_init_i (wr_data_i[BIT_INIT]),
        .wr_req_i  (wr_data_i[BIT_REQ]),
        .init_q    (init_q),
        .req_q     (req_q)
    );

    wake_core_model #(
        .WAKE_DLY (WAKE_DLY),
        .SLEEP_DLY(SLEEP_DLY)
    ) u_core (
        .clk        (clk),
        .rst        (rst),
        .sw_reset_i (sw_reset_i),
        .demand_i   (init_q && req_q),
        .clk_ready_o(ready),
        .to_sleep_o (sleepy)
    );

    wake_pin_sync #(
        .W     (PIN_W),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .pin_i({rfkill_i, board_cfg_i}),
        .pin_o(pins_s)
    );

    always_comb begin
        status = pack_status(ready, init_q, req_q, sleepy,
                             pins_s[STRAP_W-1:0], pins_s[STRAP_W],
                             pick_mode(req_q, init_q, pins_s[STRAP_W], ready));
    end

    assign rd_data_o = status;
    assign grant_o   = req_q && ready && !sleepy;
endmodule

// File: rtl/wake_ctrl_checker.sv
`timescale 1ns/1ps
module wake_ctrl_checker (
    input logic        clk,
    input logic        rst,
    input logic        sw_reset_i,
    input logic [31:0] rd_data_o,
    input logic        grant_o
);
    logic ready, init, req, sleepy;
    logic [2:0] mode;
    logic rd_unused;

    assign ready     = rd_data_o[0];
    assign init      = rd_data_o[2];
    assign req       = rd_data_o[3];
    assign sleepy    = rd_data_o[4];
    assign mode      = rd_data_o[26:24];
    assign rd_unused = ^{rd_data_o[31:27], rd_data_o[23:5], rd_data_o[1]};

    a_r5_grant_conditions: assert property (@(posedge clk) disable iff (rst)
        grant_o |-> (req && ready && !sleepy));

    a_r8_swreset_clears: assert property (@(posedge clk) disable iff (rst)
        sw_reset_i |=> (!ready && !init && !req && !sleepy && !grant_o));

    a_r3_ready_needs_demand: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> $past(init && req));

    a_r6_sleep_from_ready: assert property (@(posedge clk) disable iff (rst)
        $rose(sleepy) |-> ($past(ready) && ready));

    a_r9_none_only_when_ready: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'b000) |-> ready);

    a_r4_ready_implies_init_seen: assert property (@(posedge clk) disable iff (rst)
        (ready && !sleepy) |-> $past(init));
endmodule

bind wake_ctrl wake_ctrl_checker u_wake_ctrl_checker (
    .clk       (clk),
    .rst       (rst),
    .sw_reset_i(sw_reset_i),
    .rd_data_o (rd_data_o),
    .grant_o   (grant_o)
);

// File: tb/wake_ctrl_bench.sv
`timescale 1ns/1ps
module wake_ctrl_bench;
    localparam int WD = 3;
    localparam int SD = 2;
    localparam int SS = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sw_reset = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [3:0]  cfg = '0;
    logic        rfk = 1'b0;
    logic [31:0] rd;
    logic        grant;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    wake_ctrl #(.WAKE_DLY(WD), .SLEEP_DLY(SD), .SYNC_STAGES(SS)) u_wake_ctrl (
        .clk(clk), .rst(rst), .sw_reset_i(sw_reset), .wr_en_i(wr_en),
        .wr_data_i(wr_data), .rd_data_o(rd), .grant_o(grant),
        .board_cfg_i(cfg), .rfkill_i(rfk)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] d);
        wr_en = 1'b1;
        wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    function automatic logic [31:0] mode_of(input logic [31:0] v);
        return (v >> 24) & 32'h7;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        repeat (3) step();
        rst = 1'b0;
        chk("R1 reset word", rd, 32'h0100_0000);
        chk("R1 reset grant", {31'd0, grant}, 32'd0);

        // R3 wake timing, R5 grant, R9 mode during wake
        wr(32'h0000_000C);
        chk("R2 control bits", rd & 32'h0000_000C, 32'h0000_000C);
        for (int k = 1; k <= WD + 1; k++) begin
            step();
            chk("R3 ready timing", {31'd0, rd[0]}, (k == WD + 1) ? 32'd1 : 32'd0);
            chk("R9 mode while waking", mode_of(rd), (k == WD + 1) ? 32'd0 : 32'd1);
            chk("R5 grant on wake", {31'd0, grant}, (k == WD + 1) ? 32'd1 : 32'd0);
        end

        // R2 read-only and reserved bits ignore writes
        wr(32'hFFFF_FFFF);
        chk("R2 all-ones write", rd, 32'h0000_000D);

        // R6 release, R5 grant drops with request
        wr(32'h0000_0004);
        chk("R5 grant drop same cycle", {31'd0, grant}, 32'd0);
        for (int k = 1; k <= SD + 1; k++) begin
            step();
            chk("R6 going to sleep", {31'd0, rd[4]}, (k <= SD) ? 32'd1 : 32'd0);
            chk("R6 ready while sleeping", {31'd0, rd[0]}, (k <= SD) ? 32'd1 : 32'd0);
            chk("R5 no grant while sleeping", {31'd0, grant}, 32'd0);
        end
        chk("R9 core down after sleep", mode_of(rd), 32'd1);

        // R7 abandoned wake
        wr(32'h0000_000C);
        step();
        wr(32'h0000_0004);
        for (int k = 1; k <= WD + 2; k++) begin
            step();
            chk("R7 abandoned wake stays low", {31'd0, rd[0]}, 32'd0);
        end
        wr(32'h0000_000C);
        for (int k = 1; k <= WD + 1; k++) begin
            step();
            chk("R7 full wait after abandon", {31'd0, rd[0]}, (k == WD + 1) ? 32'd1 : 32'd0);
        end

        // R8 software reset beats a write
        sw_reset = 1'b1;
        wr_en = 1'b1;
        wr_data = 32'h0000_000C;
        step();
        sw_reset = 1'b0;
        wr_en = 1'b0;
        chk("R8 bits cleared", rd & 32'h0000_001D, 32'd0);
        chk("R8 grant cleared", {31'd0, grant}, 32'd0);
        chk("R8 mode core down", mode_of(rd), 32'd1);
        for (int k = 1; k <= WD + 3; k++) begin
            step();
            chk("R8 stays asleep", {31'd0, rd[0]}, 32'd0);
        end

        // R4 request without init-done, R9 error mode
        wr(32'h0000_0008);
        for (int k = 1; k <= WD + 3; k++) begin
            step();
            chk("R4 no ready without init", {31'd0, rd[0]}, 32'd0);
            chk("R9 error mode", mode_of(rd), 32'd3);
        end
        wr(32'h0000_0004);
        for (int k = 1; k <= WD + 3; k++) step();
        chk("R4 init alone no ready", {31'd0, rd[0]}, 32'd0);
        chk("R9 init alone core down", mode_of(rd), 32'd1);

        // R9/R10 radio kill
        wr(32'h0000_000C);
        for (int k = 1; k <= WD + 1; k++) step();
        chk("R9 awake mode none", mode_of(rd), 32'd0);
        rfk = 1'b1;
        step();
        chk("R10 radio kill one edge", {31'd0, rd[27]}, 32'd0);
        chk("R9 mode before sync", mode_of(rd), 32'd0);
        step();
        chk("R10 radio kill two edges", {31'd0, rd[27]}, 32'd1);
        chk("R9 radio down", mode_of(rd), 32'd2);
        wr(32'h0000_0008);
        chk("R9 error beats radio kill", mode_of(rd), 32'd3);
        rfk = 1'b0;
        wr(32'h0000_0000);
        for (int k = 1; k <= SD + 3; k++) step();
        chk("R9 back to core down", mode_of(rd), 32'd1);

        // R10 strap sweep
        for (int v = 0; v < 16; v++) begin
            logic [31:0] prev;
            prev = (rd >> 6) & 32'hF;
            cfg = 4'(v);
            step();
            chk("R10 strap held one edge", (rd >> 6) & 32'hF, prev);
            step();
            chk("R10 strap after two edges", (rd >> 6) & 32'hF, 32'(v));
            chk("R2 reserved zero", rd & 32'hF0FF_FC22, 32'd0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule